// File: doc/BRIEF.md
# Circular Double-Buffer DMA Channel

This block is one DMA channel that drains data words offered by a peripheral and stores them in memory, ping-ponging between two memory areas forever. Software sets two base addresses, the number of words per area and an enable bit through a small register write port. Once enabled, the channel accepts a word whenever the peripheral requests, writes it to the next word address of the active area through a single-beat memory write port with a ready input, and counts down.

When the count of the active area runs out, the channel raises a one-cycle completion pulse, sets a sticky completion flag, switches to the other area, starts again at its base and reloads the count. It never turns itself off; only a software disable stops it. The pulse can start a second engine that empties the area just filled while this channel fills the other one. The sticky flag is cleared by writing a mask to a clear register, which any bus master on the register port can do; an overrun flag records an area completing while the previous completion was still unacknowledged.

Top module: `dbdma_channel`

## Requirements
- R1: After reset the channel is disabled, `per_ack`, `mem_wr_valid`, `tc_pulse`, `tc_flag` and `ovr_flag` are 0 and `active_buf` is 0.
- R2: The register map uses word index `cfg_wr_addr`: 0 = control (bit 0 enable), 1 = area 0 base, 2 = area 1 base, 3 = words per area (nonzero), 4 = flag clear. `per_ack` is high only in a cycle where `per_req` is high and the channel is enabled, and each acknowledged word is written to memory exactly once, in order.
- R3: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` hold their values.
- R4: After enabling, the first word goes to area 0 base, and each further word of the same area goes to the previous address plus DW/8 bytes.
- R5: The write that exhausts the count of an area produces a one-cycle `tc_pulse` in the next cycle, sets `tc_flag`, toggles `active_buf`, and the following word is written at the base of the other area with a full count.
- R6: The enable bit is changed only by a control register write; the channel keeps alternating (area 0, area 1, area 0, ...) indefinitely.
- R7: Writing the clear register with bit 0 set clears `tc_flag`, with bit 1 set clears `ovr_flag`; a zero bit leaves its flag unchanged. A completion in the same cycle as a clear leaves the flag set.
- R8: A completion while `tc_flag` is already set sets `ovr_flag`; a completion with `tc_flag` clear does not.
- R9: Writing 0 to the enable bit stops new acknowledges at once, but a memory write already offered stays valid until accepted, after which `mem_wr_valid` stays low; a later enable restarts at area 0 base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 3 | Register word index |
| cfg_wr_data | input | RW | Register write data |
| per_req | input | 1 | Peripheral has a word to deliver |
| per_data | input | DW | Peripheral data word |
| per_ack | output | 1 | Word taken this cycle |
| mem_wr_valid | output | 1 | Memory write offered |
| mem_wr_addr | output | AW | Memory byte address |
| mem_wr_data | output | DW | Memory write data |
| mem_wr_ready | input | 1 | Memory accepts the offered write |
| tc_pulse | output | 1 | One-cycle area completion pulse |
| tc_flag | output | 1 | Sticky completion flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| active_buf | output | 1 | Area currently being filled |
| chan_en | output | 1 | Channel enable state |

## Verification
The main path is driven with a memory that is always ready and with one that stalls every other cycle: the first shows the address stepping and area switching at full rate, the second shows that a held write neither advances the pointer nor repeats or drops a word. A run of two and a half areas without clearing separates a correct wrap back to area 0 from a channel that stops, and shows the overrun being raised, while a run with a clear between completions shows it is not raised falsely. A disable issued while a write is stalled tells apart a channel that finishes the pending write from one that drops it or keeps acknowledging, and the re-enable shows the restart at area 0 base rather than continuing.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

    localparam int REG_IW = 3;

    typedef enum logic [REG_IW-1:0] {
        REG_CTRL  = 3'd0,
        REG_BASE0 = 3'd1,
        REG_BASE1 = 3'd2,
        REG_COUNT = 3'd3,
        REG_CLEAR = 3'd4
    } reg_idx_e;

    localparam int CTRL_EN_BIT = 0;
    localparam int CLR_TC_BIT  = 1 - 1;
    localparam int CLR_OVR_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_WRITE = 2'd2
    } xfer_state_e;

    function automatic logic reg_hit(input logic en, input logic [REG_IW-1:0] idx,
                                     input reg_idx_e which);
        return en && (idx == which);
    endfunction

endpackage

// File: rtl/dbdma_regs.sv
module dbdma_regs
    import dbdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int RW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_IW-1:0] wr_addr,
    input  logic [RW-1:0]     wr_data,
    output logic              en_q,
    output logic [AW-1:0]     base0_q,
    output logic [AW-1:0]     base1_q,
    output logic [CW-1:0]     count_q,
    output logic              clr_tc,
    output logic              clr_ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            base0_q <= '0;
            base1_q <= '0;
            count_q <= '0;
        end else begin
            if (reg_hit(wr_en, wr_addr, REG_CTRL))  en_q    <= wr_data[CTRL_EN_BIT];
            if (reg_hit(wr_en, wr_addr, REG_BASE0)) base0_q <= wr_data[AW-1:0];
            if (reg_hit(wr_en, wr_addr, REG_BASE1)) base1_q <= wr_data[AW-1:0];
            if (reg_hit(wr_en, wr_addr, REG_COUNT)) count_q <= wr_data[CW-1:0];
        end
    end

    always_comb begin
        clr_tc  = reg_hit(wr_en, wr_addr, REG_CLEAR) && wr_data[CLR_TC_BIT];
        clr_ovr = reg_hit(wr_en, wr_addr, REG_CLEAR) && wr_data[CLR_OVR_BIT];
    end
endmodule

// File: rtl/dbdma_xfer.sv
module dbdma_xfer
    import dbdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] base0,
    input  logic [AW-1:0] base1,
    input  logic [CW-1:0] count,
    input  logic          per_req,
    input  logic [DW-1:0] per_data,
    output logic          per_ack,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ready,
    output logic          buf_sel,
    output logic          tc_evt
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    xfer_state_e   state_q;
    logic [AW-1:0] ptr_q;
    logic [CW-1:0] remain_q;
    logic [DW-1:0] data_q;
    logic          buf_q;
    logic          accepted;

    always_comb begin
        per_ack   = (state_q == ST_ARMED) && en && per_req;
        mem_valid = (state_q == ST_WRITE);
        accepted  = mem_valid && mem_ready;
        tc_evt    = accepted && (remain_q == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            remain_q <= '0;
            data_q   <= '0;
            buf_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    ptr_q    <= base0;
                    remain_q <= count;
                    buf_q    <= 1'b0;
                    if (en) state_q <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (!en) begin
                        state_q <= ST_IDLE;
                    end else if (per_req) begin
                        data_q  <= per_data;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (accepted) begin
                        if (tc_evt) begin
                            buf_q    <= ~buf_q;
                            ptr_q    <= buf_q ? base0 : base1;
                            remain_q <= count;
                        end else begin
                            ptr_q    <= ptr_q + STEP;
                            remain_q <= remain_q - CW'(1);
                        end
                        state_q <= en ? ST_ARMED : ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_addr = ptr_q;
    assign mem_data = data_q;
    assign buf_sel  = buf_q;
endmodule

// File: rtl/dbdma_flags.sv
module dbdma_flags (
    input  logic clk,
    input  logic rst,
    input  logic tc_evt,
    input  logic clr_tc,
    input  logic clr_ovr,
    output logic tc_pulse_q,
    output logic tc_flag_q,
    output logic ovr_flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tc_pulse_q <= 1'b0;
            tc_flag_q  <= 1'b0;
            ovr_flag_q <= 1'b0;
        end else begin
            tc_pulse_q <= tc_evt;
            if (tc_evt)      tc_flag_q <= 1'b1;
            else if (clr_tc) tc_flag_q <= 1'b0;
            if (tc_evt && tc_flag_q) ovr_flag_q <= 1'b1;
            else if (clr_ovr)        ovr_flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dbdma_channel.sv
module dbdma_channel
    import dbdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16,
    parameter int RW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [REG_IW-1:0] cfg_wr_addr,
    input  logic [RW-1:0]     cfg_wr_data,
    input  logic              per_req,
    input  logic [DW-1:0]     per_data,
    output logic              per_ack,
    output logic              mem_wr_valid,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [DW-1:0]     mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              tc_pulse,
    output logic              tc_flag,
    output logic              ovr_flag,
    output logic              active_buf,
    output logic              chan_en
);
    logic [AW-1:0] base0, base1;
    logic [CW-1:0] count;
    logic          clr_tc, clr_ovr, tc_evt;

    dbdma_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
        .en_q(chan_en), .base0_q(base0), .base1_q(base1), .count_q(count),
        .clr_tc(clr_tc), .clr_ovr(clr_ovr)
    );

    dbdma_xfer #(.AW(AW), .DW(DW), .CW(CW)) u_xfer (
        .clk(clk), .rst(rst), .en(chan_en),
        .base0(base0), .base1(base1), .count(count),
        .per_req(per_req), .per_data(per_data), .per_ack(per_ack),
        .mem_valid(mem_wr_valid), .mem_addr(mem_wr_addr), .mem_data(mem_wr_data),
        .mem_ready(mem_wr_ready), .buf_sel(active_buf), .tc_evt(tc_evt)
    );

    dbdma_flags u_flags (
        .clk(clk), .rst(rst), .tc_evt(tc_evt),
        .clr_tc(clr_tc), .clr_ovr(clr_ovr),
        .tc_pulse_q(tc_pulse), .tc_flag_q(tc_flag), .ovr_flag_q(ovr_flag)
    );
endmodule

// File: rtl/dbdma_channel_chk.sv
module dbdma_channel_chk
    import dbdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [REG_IW-1:0] cfg_wr_addr,
    input logic [RW-1:0]     cfg_wr_data,
    input logic              per_req,
    input logic              per_ack,
    input logic              mem_wr_valid,
    input logic [AW-1:0]     mem_wr_addr,
    input logic [DW-1:0]     mem_wr_data,
    input logic              mem_wr_ready,
    input logic              tc_pulse,
    input logic              tc_flag,
    input logic              ovr_flag,
    input logic              active_buf,
    input logic              chan_en
);
    p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> (per_req && chan_en));

    p_hold_write_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    p_tc_single_r5: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse);

    p_tc_swaps_r5: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> (tc_flag && (active_buf != $past(active_buf))));

    p_en_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !(cfg_wr_en && cfg_wr_addr == REG_CTRL)) |=> chan_en);

    p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse && $past(tc_flag)) |-> ovr_flag);

    p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!chan_en && !mem_wr_valid) |=> !mem_wr_valid);
endmodule

bind dbdma_channel dbdma_channel_chk #(.AW(AW), .DW(DW), .RW(RW)) u_chk (.*);

// File: tb/dbdma_channel_tb.sv
module dbdma_channel_tb;
    import dbdma_pkg::*;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int RW = 32;
    localparam logic [DW-1:0] DATA0 = 32'hD000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              cfg_wr_en = 1'b0;
    logic [REG_IW-1:0] cfg_wr_addr = '0;
    logic [RW-1:0]     cfg_wr_data = '0;
    logic              per_req, per_ack;
    logic [DW-1:0]     per_data;
    logic              mem_wr_valid, mem_wr_ready;
    logic [AW-1:0]     mem_wr_addr;
    logic [DW-1:0]     mem_wr_data;
    logic              tc_pulse, tc_flag, ovr_flag, active_buf, chan_en;

    int total = 0;
    int bad   = 0;

    // peripheral model: delivers words until prod_acked reaches prod_total
    int prod_total = 0;
    int prod_acked = 0;
    assign per_req  = (prod_acked != prod_total);
    assign per_data = DATA0 + DW'(prod_acked);
    always @(posedge clk) if (!rst && per_req && per_ack) prod_acked <= prod_acked + 1;

    // memory model
    logic stall_mode = 1'b0;
    logic ready_fix  = 1'b1;
    always @(negedge clk) begin
        if (stall_mode) mem_wr_ready <= ~mem_wr_ready;
        else            mem_wr_ready <= ready_fix;
    end
    logic [AW-1:0] log_addr [0:63];
    logic [DW-1:0] log_data [0:63];
    int log_n  = 0;
    int tc_cnt = 0;
    always @(posedge clk) begin
        if (!rst && mem_wr_valid && mem_wr_ready) begin
            log_addr[log_n % 64] <= mem_wr_addr;
            log_data[log_n % 64] <= mem_wr_data;
            log_n <= log_n + 1;
        end
        if (!rst && tc_pulse) tc_cnt <= tc_cnt + 1;
    end

    dbdma_channel #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .per_req(per_req), .per_data(per_data), .per_ack(per_ack),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(mem_wr_ready),
        .tc_pulse(tc_pulse), .tc_flag(tc_flag), .ovr_flag(ovr_flag),
        .active_buf(active_buf), .chan_en(chan_en)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input reg_idx_e idx, input logic [RW-1:0] val);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = idx;
        cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_log(input int target, input string req);
        int spin = 0;
        while (log_n < target && spin < 2000) begin
            @(negedge clk);
            spin++;
        end
        check(log_n >= target, req, 64'(log_n), 64'(target));
    endtask

    // check logged writes [first, first+n) against area layout
    task automatic check_run(input int first, input int n, input int cnt,
                             input logic [AW-1:0] b0, input logic [AW-1:0] b1,
                             input int data_first, input string req);
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] ea;
            ea = (((k / cnt) % 2) == 0 ? b0 : b1) + AW'(4 * (k % cnt));
            check(log_addr[(first + k) % 64] == ea, req,
                  64'(log_addr[(first + k) % 64]), 64'(ea));
            check(log_data[(first + k) % 64] == DATA0 + DW'(data_first + k), req,
                  64'(log_data[(first + k) % 64]), 64'(DATA0 + DW'(data_first + k)));
        end
    endtask

    task automatic stop_channel();
        reg_write(REG_CTRL, 32'h0);
        idle(4);
        reg_write(REG_CLEAR, 32'h3);
    endtask

    task automatic t_reset();
        check(chan_en == 1'b0,      "R1 enable",  64'(chan_en), 64'(0));
        check(per_ack == 1'b0,      "R1 ack",     64'(per_ack), 64'(0));
        check(mem_wr_valid == 1'b0, "R1 valid",   64'(mem_wr_valid), 64'(0));
        check(tc_pulse == 1'b0 && tc_flag == 1'b0 && ovr_flag == 1'b0, "R1 flags",
              64'({tc_pulse, tc_flag, ovr_flag}), 64'(0));
        check(active_buf == 1'b0,   "R1 area",    64'(active_buf), 64'(0));
    endtask

    // R4 R5 R6 R8: 10 words, 4 per area, full-rate memory, no clears
    task automatic t_full_rate();
        int l0, d0, t0;
        l0 = log_n; d0 = prod_acked; t0 = tc_cnt;
        reg_write(REG_BASE0, 32'h0000_1000);
        reg_write(REG_BASE1, 32'h0000_2000);
        reg_write(REG_COUNT, 32'd4);
        reg_write(REG_CTRL, 32'h1);
        prod_total = prod_total + 10;
        wait_log(l0 + 10, "R2 ten words written");
        idle(4);
        check(log_n == l0 + 10, "R2 no extra writes", 64'(log_n - l0), 64'(10));
        check_run(l0, 10, 4, 32'h1000, 32'h2000, d0, "R4 R5 address/data");
        check(tc_cnt - t0 == 2, "R5 two completions", 64'(tc_cnt - t0), 64'(2));
        check(active_buf == 1'b0, "R6 wrapped to area 0", 64'(active_buf), 64'(0));
        check(chan_en == 1'b1, "R6 still enabled", 64'(chan_en), 64'(1));
        check(tc_flag == 1'b1, "R5 flag set", 64'(tc_flag), 64'(1));
        check(ovr_flag == 1'b1, "R8 overrun on unacknowledged completion",
              64'(ovr_flag), 64'(1));
    endtask

    // R7: clear masks
    task automatic t_clear();
        reg_write(REG_CLEAR, 32'h0);
        idle(1);
        check(tc_flag && ovr_flag, "R7 zero mask no effect", 64'({tc_flag, ovr_flag}), 64'(3));
        reg_write(REG_CLEAR, 32'h1);
        idle(1);
        check(!tc_flag && ovr_flag, "R7 bit0 clears tc only", 64'({tc_flag, ovr_flag}), 64'(1));
        reg_write(REG_CLEAR, 32'h2);
        idle(1);
        check(!tc_flag && !ovr_flag, "R7 bit1 clears overrun", 64'({tc_flag, ovr_flag}), 64'(0));
    endtask

    // R3 R8: stalling memory, clear between completions
    task automatic t_stall();
        int l0, d0;
        stop_channel();
        l0 = log_n; d0 = prod_acked;
        stall_mode = 1'b1;
        reg_write(REG_BASE0, 32'h0000_4000);
        reg_write(REG_BASE1, 32'h0000_8000);
        reg_write(REG_COUNT, 32'd3);
        reg_write(REG_CTRL, 32'h1);
        prod_total = prod_total + 3;
        wait_log(l0 + 3, "R3 first area under stall");
        idle(3);
        check(tc_flag && !ovr_flag && active_buf, "R8 single completion no overrun",
              64'({tc_flag, ovr_flag, active_buf}), 64'(5));
        reg_write(REG_CLEAR, 32'h1);
        prod_total = prod_total + 3;
        wait_log(l0 + 6, "R3 second area under stall");
        idle(3);
        check(tc_flag && !ovr_flag, "R8 cleared flag prevents overrun",
              64'({tc_flag, ovr_flag}), 64'(2));
        check_run(l0, 6, 3, 32'h4000, 32'h8000, d0, "R3 R4 stalled address/data");
        stall_mode = 1'b0;
        ready_fix  = 1'b1;
    endtask

    // R9: disable with a write pending, then restart
    task automatic t_disable();
        int l0, d0, spin;
        stop_channel();
        l0 = log_n; d0 = prod_acked;
        ready_fix = 1'b0;
        idle(2);
        reg_write(REG_BASE0, 32'h0000_A000);
        reg_write(REG_COUNT, 32'd4);
        reg_write(REG_CTRL, 32'h1);
        prod_total = prod_total + 1;
        spin = 0;
        while (!mem_wr_valid && spin < 100) begin @(negedge clk); spin++; end
        reg_write(REG_CTRL, 32'h0);
        check(mem_wr_valid == 1'b1, "R9 pending write kept", 64'(mem_wr_valid), 64'(1));
        check(chan_en == 1'b0, "R9 disabled", 64'(chan_en), 64'(0));
        prod_total = prod_total + 1;
        idle(5);
        check(prod_acked == d0 + 1, "R9 no acknowledge while disabled",
              64'(prod_acked - d0), 64'(1));
        ready_fix = 1'b1;
        idle(4);
        check(log_n == l0 + 1, "R9 pending write delivered once", 64'(log_n - l0), 64'(1));
        check(mem_wr_valid == 1'b0, "R9 quiet after drain", 64'(mem_wr_valid), 64'(0));
        check(log_addr[l0 % 64] == 32'hA000, "R9 pending write address",
              64'(log_addr[l0 % 64]), 64'(32'hA000));
        reg_write(REG_CTRL, 32'h1);
        wait_log(l0 + 2, "R9 word after re-enable");
        check(log_addr[(l0 + 1) % 64] == 32'hA000, "R9 restart at area 0 base",
              64'(log_addr[(l0 + 1) % 64]), 64'(32'hA000));
        check(log_data[(l0 + 1) % 64] == DATA0 + DW'(d0 + 1), "R2 second word data",
              64'(log_data[(l0 + 1) % 64]), 64'(DATA0 + DW'(d0 + 1)));
    endtask

    initial begin
        mem_wr_ready = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_full_rate();
        t_clear();
        t_stall();
        t_disable();
        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule